// File: doc/BRIEF.md
# Focal-Point Phase Calculator

This block turns one focal-point entry into a drive phase for every transducer of an array. An entry arrives as four packed 16-bit words that carry a signed three-dimensional focus position and an 8-bit intensity. The caller presents the words with a one-cycle `start` pulse, together with the two 16-bit halves of the sound-speed value.

After the start, the block pulls transducer positions one at a time through a valid/ready handshake. For each position it forms the squared Euclidean distance to the focus. A bit-serial non-restoring square root turns that into an integer distance. The distance is shifted left by 18 and divided by the sound speed in a bit-serial restoring divider. The low 8 bits of the quotient are the phase. Each result leaves as an (intensity, phase) pair marked by a one-cycle `out_valid` pulse. After `NUM_TR` results the block returns to idle.

Only one transducer is in flight at a time. Pattern sequencing and pulse-width generation belong to neighbouring blocks.

Top module: `focal_phase_calc`

## Requirements
- R1: The focus x coordinate is 18 bits wide. Bits [15:0] come from `ent_w0[15:0]` and bits [17:16] from `ent_w1[1:0]`. The value is two's complement, sign-extended from bit 17.
- R2: The focus y coordinate is 18 bits wide. Bits [13:0] come from `ent_w1[15:2]` and bits [17:14] from `ent_w2[3:0]`. It is two's complement.
- R3: The focus z coordinate is 18 bits wide. Bits [11:0] come from `ent_w2[15:4]` and bits [17:12] from `ent_w3[5:0]`. It is two's complement.
- R4: The intensity is `ent_w3[13:6]`. Every result of the entry carries that same intensity, and `ent_w3[15:14]` has no effect on any result.
- R5: A position word holds three signed 16-bit values: x in bits [31:16], y in bits [15:0] and z in bits [47:32].
- R6: The distance is floor(sqrt(dx²+dy²+dz²)), where each difference is the focus coordinate minus the transducer coordinate.
- R7: The sound speed is {`spd_hi`,`spd_lo`}, taken as 32 bits unsigned. The phase equals bits [7:0] of floor((distance·2^18)/speed).
- R8: A zero sound speed forces every phase of the entry to 0 and raises `spd_err`. `spd_err` stays high until the next accepted start that carries a nonzero speed.
- R9: Each accepted position produces exactly one single-cycle `out_valid` pulse, and the results come out in acceptance order. After `NUM_TR` results, `busy` and `pos_ready` are low.
- R10: `pos_ready` is high only while the block waits for a position. A `start` pulse while `busy` is high has no effect on the entry in progress.
- R11: After reset, `busy`, `pos_ready`, `out_valid` and `spd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latches entry words and speed when idle |
| ent_w0 | input | 16 | Entry word 0 |
| ent_w1 | input | 16 | Entry word 1 |
| ent_w2 | input | 16 | Entry word 2 |
| ent_w3 | input | 16 | Entry word 3 |
| spd_lo | input | 16 | Sound speed, low half |
| spd_hi | input | 16 | Sound speed, high half |
| pos_valid | input | 1 | Transducer position is offered |
| pos_data | input | 48 | Packed transducer position |
| pos_ready | output | 1 | Block accepts a position this cycle |
| out_valid | output | 1 | One-cycle result strobe |
| out_intensity | output | 8 | Intensity of the entry |
| out_phase | output | 8 | Drive phase of the current transducer |
| spd_err | output | 1 | Sound speed was zero |
| busy | output | 1 | Entry in progress |

## Verification
Some internal faults show up only as wrong phase values. A mistake in the square-root remainder sign, in the divider borrow, or in which bits a coordinate is drawn from falls in this group. Each such fault appears at the first `out_valid` pulse, 57 cycles after the position is accepted. The bench therefore compares every phase against an independent integer model. It uses both negative and extreme coordinates, so that sign extension and the full radicand width are both exercised. A wrong transducer counter or state shows up in a different way. `busy` or `pos_ready` stays high after the last result, or a result is missing, and this is visible within one cycle of the final pulse.

// File: rtl/focal_phase_calc.sv
module focal_phase_calc #(
  parameter int NUM_TR = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] ent_w0,
  input  logic [15:0] ent_w1,
  input  logic [15:0] ent_w2,
  input  logic [15:0] ent_w3,
  input  logic [15:0] spd_lo,
  input  logic [15:0] spd_hi,
  input  logic        pos_valid,
  input  logic [47:0] pos_data,
  output logic        pos_ready,
  output logic        out_valid,
  output logic [7:0]  out_intensity,
  output logic [7:0]  out_phase,
  output logic        spd_err,
  output logic        busy
);
  localparam int CW     = 18;
  localparam int DW     = CW + 1;
  localparam int RAD_W  = 2 * DW;
  localparam int ROOT_W = RAD_W / 2;
  localparam int REM_W  = ROOT_W + 6;
  localparam int SHIFT  = 18;
  localparam int DVD_W  = ROOT_W + SHIFT;
  localparam int CNT_W  = (NUM_TR > 1) ? $clog2(NUM_TR) : 1;

  typedef enum logic [1:0] {S_IDLE, S_POS, S_SQRT, S_DIV} state_t;
  state_t state;

  logic signed [CW-1:0] fx, fy, fz;
  logic [31:0]          spd;
  logic [CNT_W-1:0]     cnt;
  logic [5:0]           step;
  logic [RAD_W-1:0]     rad;
  logic [ROOT_W-1:0]    root;
  logic [REM_W-1:0]     rem;
  logic [DVD_W-1:0]     dvd;
  logic [31:0]          drem;
  logic [7:0]           q;

  logic unused_w3;
  assign unused_w3 = ^ent_w3[15:14];

  wire [31:0] spd_in = {spd_hi, spd_lo};

  logic signed [DW-1:0] dx, dy, dz;
  logic signed [RAD_W-1:0] sx, sy, sz;
  logic [RAD_W-1:0] d2;
  assign dx = DW'(fx) - DW'($signed(pos_data[31:16]));
  assign dy = DW'(fy) - DW'($signed(pos_data[15:0]));
  assign dz = DW'(fz) - DW'($signed(pos_data[47:32]));
  assign sx = dx * dx;
  assign sy = dy * dy;
  assign sz = dz * dz;
  assign d2 = sx + sy + sz;

  logic [REM_W-1:0]  rem_sh, rem_nx;
  logic [ROOT_W-1:0] root_nx;
  assign rem_sh  = {rem[REM_W-3:0], rad[RAD_W-1 -: 2]};
  assign rem_nx  = rem[REM_W-1] ? rem_sh + REM_W'({root, 2'b11})
                                : rem_sh - REM_W'({root, 2'b01});
  assign root_nx = {root[ROOT_W-2:0], ~rem_nx[REM_W-1]};

  logic [33:0] trial;
  logic        borrow;
  assign trial  = {1'b0, drem, dvd[DVD_W-1]} - {2'b00, spd};
  assign borrow = trial[33];

  assign busy      = (state != S_IDLE);
  assign pos_ready = (state == S_POS);

  wire last = (cnt == CNT_W'(NUM_TR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      out_valid     <= 1'b0;
      out_phase     <= '0;
      out_intensity <= '0;
      spd_err       <= 1'b0;
      fx <= '0; fy <= '0; fz <= '0;
      spd <= '0; cnt <= '0; step <= '0;
      rad <= '0; root <= '0; rem <= '0;
      dvd <= '0; drem <= '0; q <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fx            <= $signed({ent_w1[1:0], ent_w0});
          fy            <= $signed({ent_w2[3:0], ent_w1[15:2]});
          fz            <= $signed({ent_w3[5:0], ent_w2[15:4]});
          out_intensity <= ent_w3[13:6];
          spd           <= spd_in;
          spd_err       <= (spd_in == 32'd0);
          cnt           <= '0;
          state         <= S_POS;
        end
        S_POS: if (pos_valid) begin
          rad   <= d2;
          rem   <= '0;
          root  <= '0;
          step  <= 6'(ROOT_W - 1);
          state <= S_SQRT;
        end
        S_SQRT: begin
          rad  <= rad << 2;
          rem  <= rem_nx;
          root <= root_nx;
          step <= step - 6'd1;
          if (step == 6'd0) begin
            if (spd == 32'd0) begin
              out_valid <= 1'b1;
              out_phase <= 8'd0;
              cnt       <= cnt + 1'b1;
              state     <= last ? S_IDLE : S_POS;
            end else begin
              dvd   <= {root_nx, {SHIFT{1'b0}}};
              drem  <= '0;
              q     <= '0;
              step  <= 6'(DVD_W - 1);
              state <= S_DIV;
            end
          end
        end
        S_DIV: begin
          dvd  <= dvd << 1;
          drem <= borrow ? {drem[30:0], dvd[DVD_W-1]} : trial[31:0];
          q    <= {q[6:0], ~borrow};
          step <= step - 6'd1;
          if (step == 6'd0) begin
            out_valid <= 1'b1;
            out_phase <= {q[6:0], ~borrow};
            cnt       <= cnt + 1'b1;
            state     <= last ? S_IDLE : S_POS;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module focal_phase_calc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       pos_valid,
  input logic       pos_ready,
  input logic       out_valid,
  input logic [7:0] out_phase,
  input logic       spd_err,
  input logic       busy
);
  p_ready_in_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pos_ready |-> busy);
  p_start_opens_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && pos_ready));
  p_accept_then_compute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && pos_ready) |=> (!pos_ready && !out_valid));
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_zero_speed_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && spd_err) |-> (out_phase == 8'd0));
endmodule

bind focal_phase_calc focal_phase_calc_chk u_chk (.*);

// File: tb/test_focal_phase_calc.sv
module test_focal_phase_calc;
  localparam int CLK_PERIOD = 10;
  localparam int NTR = 4;

  logic clk = 0, rst_n = 0, start = 0, pos_valid = 0;
  logic [15:0] ent_w0 = 0, ent_w1 = 0, ent_w2 = 0, ent_w3 = 0, spd_lo = 0, spd_hi = 0;
  logic [47:0] pos_data = 0;
  logic pos_ready, out_valid, spd_err, busy;
  logic [7:0] out_intensity, out_phase;

  int errors = 0, checks = 0, cyc = 0;
  int tpx[NTR], tpy[NTR], tpz[NTR];

  focal_phase_calc #(.NUM_TR(NTR)) i_focal_phase_calc (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: act=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint n);
    longint lo = 0, hi = 1 << 20;
    while (hi - lo > 1) begin
      longint m = (lo + hi) / 2;
      if (m * m <= n) lo = m; else hi = m;
    end
    return lo;
  endfunction

  function automatic int exp_phase(input int x, y, z, tx, ty, tz, input longint spd);
    longint dx = x - tx, dy = y - ty, dz = z - tz;
    longint d = isqrt(dx*dx + dy*dy + dz*dz);
    if (spd == 0) return 0;
    return int'(((d << 18) / spd) & 255);
  endfunction

  task automatic load_words(input int x, y, z, input int inten, input logic [1:0] junk);
    logic [17:0] x18 = x[17:0], y18 = y[17:0], z18 = z[17:0];
    logic [7:0] i8 = inten[7:0];
    ent_w0 = x18[15:0];
    ent_w1 = {y18[13:0], x18[17:16]};
    ent_w2 = {z18[11:0], y18[17:14]};
    ent_w3 = {junk, i8, z18[17:12]};
  endtask

  task automatic run_entry(input string tag, input int x, y, z, input int inten,
                           input logic [31:0] speed, input bit poke);
    load_words(x, y, z, inten, 2'b11);
    {spd_hi, spd_lo} = speed;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t < NTR; t++) begin
      int to = 0;
      while (!pos_ready && to < 200) begin @(negedge clk); to++; end
      chk(pos_ready, {tag, " R10 pos_ready"}, pos_ready, 1);
      pos_data = {tpz[t][15:0], tpx[t][15:0], tpy[t][15:0]};
      pos_valid = 1;
      @(negedge clk);
      pos_valid = 0;
      to = 0;
      while (!out_valid && to < 200) begin @(negedge clk); to++; end
      chk(out_valid, {tag, " R9 result strobe"}, out_valid, 1);
      chk(out_intensity == inten[7:0], {tag, " R4 intensity"}, out_intensity, inten);
      begin
        int e = exp_phase(x, y, z, tpx[t], tpy[t], tpz[t], speed);
        chk(out_phase == e[7:0], {tag, " R6 R7 phase"}, out_phase, e);
      end
      chk(spd_err == (speed == 0), {tag, " R8 spd_err"}, spd_err, speed == 0);
      if (t == NTR - 1) begin
        chk(!busy && !pos_ready, {tag, " R9 idle after last"}, {busy, pos_ready}, 0);
      end
      if (poke && t == 0) begin
        load_words(-5000, 7000, 123, 8'h11, 2'b00);
        {spd_hi, spd_lo} = 32'd999;
        start = 1;
      end
      @(negedge clk);
      start = 0;
      chk(!out_valid, {tag, " R9 single pulse"}, out_valid, 0);
    end
  endtask

  task automatic t_reset;
    chk(!busy && !pos_ready && !out_valid && !spd_err, "R11 reset state",
        {busy, pos_ready, out_valid, spd_err}, 0);
  endtask

  task automatic t_basic;
    tpx = '{0, 406, -812, 6000}; tpy = '{0, 0, 406, -3000}; tpz = '{0, 0, 0, 100};
    run_entry("basic R1 R5", 1000, 2000, 30000, 8'hA5, 32'h0001_5400, 0);
  endtask

  task automatic t_negative;
    tpx = '{-100, 2000, 0, -32768}; tpy = '{50, -2000, 32767, 0}; tpz = '{0, -7, 12, 0};
    run_entry("neg R2 R3", -70000, -12345, -99999, 8'h3C, 32'd7, 0);
  endtask

  task automatic t_extreme;
    tpx = '{32767, -32768, 32767, 1}; tpy = '{-32768, 32767, 32767, 1};
    tpz = '{32767, -32768, -32768, 1};
    run_entry("extreme R1 R2 R3 R6", -131072, 131071, -131072, 8'hFF, 32'hFFFF_FFFF, 0);
    run_entry("extreme2 R7", 131071, -131072, 131071, 8'h00, 32'd3, 0);
  endtask

  task automatic t_zero_speed;
    tpx = '{10, 20, 30, 40}; tpy = '{1, 2, 3, 4}; tpz = '{5, 5, 5, 5};
    run_entry("zero R8", 500, 600, 700, 8'h42, 32'd0, 0);
    run_entry("clear R8", 500, 600, 700, 8'h42, 32'd340, 0);
  endtask

  task automatic t_start_ignored;
    tpx = '{100, 200, 300, 400}; tpy = '{-1, -2, -3, -4}; tpz = '{9, 8, 7, 6};
    run_entry("busy start R10", 12000, -8000, 40000, 8'h77, 32'h0000_4000, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_negative();
    t_extreme();
    t_zero_speed();
    t_start_ignored();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule